// File: doc/BRIEF.md
# Fractional-N Feedback Ratio Generator

This block holds the digital dividers of a sigma-delta fractional-N frequency synthesizer. In the reference clock domain, a down-counter emits a one-cycle enable that sets the comparison rate for the phase detector. In the oscillator clock domain, a second down-counter divides the oscillator clock. The length of each feedback period is chosen again at every period end. It is the programmed integer ratio plus a small signed correction from a third-order cascaded modulator driven by a 20-bit fraction, so that the long-run ratio is the integer plus the fraction over 2^20. For example, a 20 MHz reference with unit reference division reaches 1575.42 MHz with integer 78 and fraction 808452. It reaches 1227.6 MHz with integer 61 and fraction 398459.

A mode input chooses between integer and fractional operation. A low-power request is legal only for some integer ratios. The block checks the programmed ratios against the limits that belong to each mode. An illegal setting raises a configuration-error flag, and the affected divider keeps running on the last legal setting it accepted. The block takes new settings only when a period ends, so a period already in progress always runs to its chosen length.

Top module: `fracn_ratio_gen`

## Requirements
- R1: While reset is asserted and right after it, the error flag is low, the reference divisor is 1 (so the reference pulse stays high), and the feedback divisor is 78. The first feedback pulse after reset release therefore appears 77 oscillator cycles later.
- R2: With a reference divisor D from 1 to 1023, consecutive reference pulses are D reference cycles apart, and each pulse is one cycle wide.
- R3: A reference divisor of 0 sets the error flag one oscillator cycle later, and the reference divider keeps its previous period.
- R4: In integer mode (frac_mode = 0), every feedback period equals the integer divisor, whatever the fractional word holds.
- R5: An integer divisor below 36 sets the error flag one cycle later and is not adopted. Values from 36 up to 32767 are accepted in integer mode.
- R6: In fractional mode (frac_mode = 1), an integer divisor above 251 sets the error flag and is not adopted.
- R7: The low-power request (lp_req = 1) is legal only in integer mode with an integer divisor whose five low bits are zero. In any other case it sets the error flag and the setting is not adopted.
- R8: In fractional mode, each feedback period is N + y with y = c1 + c2 - c2' + c3 - 2*c3' + c3''. Here c1..c3 are the carries out of three cascaded 20-bit accumulators: the first adds the fraction, and each later one adds the previous sum. Primes mark the carry from one and two earlier period ends. y always lies in -3..+4.
- R9: In fractional mode with a zero fraction, the modulator is cleared and every period equals N.
- R10: New settings are sampled only at the cycle in which the feedback pulse is high. Between pulses the feedback counter falls by exactly one per cycle, so a change made mid-period does not alter that period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock |
| vco_clk | input | 1 | Oscillator-rate clock for the feedback divider |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| ref_div | input | 10 | Reference divisor |
| int_div | input | 15 | Integer part of the feedback ratio |
| frac_word | input | 20 | Fractional part of the ratio, in units of 2^-20 |
| frac_mode | input | 1 | 1 selects fractional operation, 0 integer |
| lp_req | input | 1 | Low-power option request |
| ref_pulse | output | 1 | Divided reference enable |
| fb_pulse | output | 1 | Divided feedback pulse, high in the last cycle of each period |
| cfg_err | output | 1 | Configuration error flag, registered in the oscillator domain |

## Verification
Several properties are checked on every clock cycle. Each range violation must raise the flag on the next cycle. The feedback counter must fall by one between pulses. The modulator correction must stay within -3..+4, and it must be zero whenever the modulator is bypassed. Other behaviour shows up only in the bench's scenarios. These are the exact sequence of dithered period lengths for the two example ratios, the retention of the old setting after an illegal one, the reference periods, and the way a mid-period change is deferred. A scoreboard compares each of these, period by period, against an independent model of the modulator equation.

// File: rtl/frg_pkg.sv
package frg_pkg;
   localparam int MASH_ORDER = 3;
   localparam int OFS_W      = 4;
   typedef logic signed [OFS_W-1:0] ofs_t;
endpackage

// File: rtl/frg_cfg_check.sv
module frg_cfg_check #(
   parameter int REF_W        = 10,
   parameter int INT_W        = 15,
   parameter int INT_MIN      = 36,
   parameter int FRAC_INT_MAX = 251,
   parameter int LP_ALIGN_LOG = 5
) (
   input  logic [REF_W-1:0] ref_div,
   input  logic [INT_W-1:0] int_div,
   input  logic             frac_mode,
   input  logic             lp_req,
   output logic             ref_ok,
   output logic             fb_ok
);
   logic too_low, too_high_frac, lp_bad, misaligned;

   assign ref_ok        = (ref_div != '0);
   assign too_low       = (int_div < INT_W'(INT_MIN));
   assign too_high_frac = frac_mode && (int_div > INT_W'(FRAC_INT_MAX));

   generate
      if (LP_ALIGN_LOG > 0) begin : g_align
         assign misaligned = (int_div[LP_ALIGN_LOG-1:0] != '0);
      end else begin : g_noalign
         assign misaligned = 1'b0;
      end
   endgenerate

   assign lp_bad = lp_req && (frac_mode || misaligned);
   assign fb_ok  = !(too_low || too_high_frac || lp_bad);
endmodule

// File: rtl/frg_ref_divider.sv
module frg_ref_divider #(
   parameter int REF_W   = 10,
   parameter int RST_REF = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REF_W-1:0] ref_div,
   input  logic             ref_ok,
   output logic             pulse
);
   logic [REF_W-1:0] cnt_q, act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= REF_W'(RST_REF - 1);
         act_q <= REF_W'(RST_REF);
      end else if (cnt_q == '0) begin
         if (ref_ok) begin
            act_q <= ref_div;
            cnt_q <= ref_div - 1'b1;
         end else begin
            cnt_q <= act_q - 1'b1;
         end
      end else begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign pulse = (cnt_q == '0);
endmodule

// File: rtl/frg_mash3.sv
module frg_mash3
   import frg_pkg::*;
#(
   parameter int FRAC_W = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic              bypass,
   input  logic [FRAC_W-1:0] frac_in,
   output ofs_t              offset
);
   logic [FRAC_W-1:0] acc_q [MASH_ORDER];
   logic [FRAC_W-1:0] sum_w [MASH_ORDER];
   logic [MASH_ORDER-1:0] car_w;
   logic c2_d1, c3_d1, c3_d2;
   logic [OFS_W-1:0] raw;

   generate
      for (genvar s = 0; s < MASH_ORDER; s++) begin : g_stage
         logic [FRAC_W:0] add_w;
         if (s == 0) begin : g_first
            assign add_w = {1'b0, acc_q[s]} + {1'b0, frac_in};
         end else begin : g_next
            assign add_w = {1'b0, acc_q[s]} + {1'b0, sum_w[s-1]};
         end
         assign sum_w[s] = add_w[FRAC_W-1:0];
         assign car_w[s] = add_w[FRAC_W];
      end
   endgenerate

   assign raw = OFS_W'(car_w[0]) + OFS_W'(car_w[1]) - OFS_W'(c2_d1)
              + OFS_W'(car_w[2]) - OFS_W'({c3_d1, 1'b0}) + OFS_W'(c3_d2);
   assign offset = bypass ? ofs_t'(0) : $signed(raw);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < MASH_ORDER; s++) acc_q[s] <= '0;
         c2_d1 <= 1'b0;
         c3_d1 <= 1'b0;
         c3_d2 <= 1'b0;
      end else if (step) begin
         if (bypass) begin
            for (int s = 0; s < MASH_ORDER; s++) acc_q[s] <= '0;
            c2_d1 <= 1'b0;
            c3_d1 <= 1'b0;
            c3_d2 <= 1'b0;
         end else begin
            for (int s = 0; s < MASH_ORDER; s++) acc_q[s] <= sum_w[s];
            c2_d1 <= car_w[1];
            c3_d1 <= car_w[2];
            c3_d2 <= c3_d1;
         end
      end
   end
endmodule

// File: rtl/frg_fb_counter.sv
module frg_fb_counter
   import frg_pkg::*;
#(
   parameter int INT_W   = 15,
   parameter int FRAC_W  = 20,
   parameter int RST_INT = 78
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [INT_W-1:0]  int_div,
   input  logic [FRAC_W-1:0] frac_word,
   input  logic              frac_mode,
   input  logic              fb_ok,
   input  ofs_t              offset,
   output logic              pulse,
   output logic [INT_W-1:0]  cnt,
   output logic [FRAC_W-1:0] sel_frac,
   output logic              bypass
);
   logic [INT_W-1:0]  cnt_q, act_int_q, sel_int;
   logic [FRAC_W-1:0] act_frac_q;
   logic              act_mode_q, sel_mode;
   logic signed [INT_W:0] nxt_div;

   assign pulse    = (cnt_q == '0);
   assign cnt      = cnt_q;
   assign sel_int  = fb_ok ? int_div   : act_int_q;
   assign sel_frac = fb_ok ? frac_word : act_frac_q;
   assign sel_mode = fb_ok ? frac_mode : act_mode_q;
   assign bypass   = !sel_mode || (sel_frac == '0);
   assign nxt_div  = $signed({1'b0, sel_int}) + (INT_W+1)'(offset);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q      <= INT_W'(RST_INT - 1);
         act_int_q  <= INT_W'(RST_INT);
         act_frac_q <= '0;
         act_mode_q <= 1'b0;
      end else if (pulse) begin
         act_int_q  <= sel_int;
         act_frac_q <= sel_frac;
         act_mode_q <= sel_mode;
         cnt_q      <= INT_W'(nxt_div - 1);
      end else begin
         cnt_q <= cnt_q - 1'b1;
      end
   end
endmodule

// File: rtl/fracn_ratio_gen.sv
module fracn_ratio_gen
   import frg_pkg::*;
#(
   parameter int REF_W        = 10,
   parameter int INT_W        = 15,
   parameter int FRAC_W       = 20,
   parameter int INT_MIN      = 36,
   parameter int FRAC_INT_MAX = 251,
   parameter int LP_ALIGN_LOG = 5,
   parameter int RST_INT      = 78,
   parameter int RST_REF      = 1
) (
   input  logic              ref_clk,
   input  logic              vco_clk,
   input  logic              rst_n,
   input  logic [REF_W-1:0]  ref_div,
   input  logic [INT_W-1:0]  int_div,
   input  logic [FRAC_W-1:0] frac_word,
   input  logic              frac_mode,
   input  logic              lp_req,
   output logic              ref_pulse,
   output logic              fb_pulse,
   output logic              cfg_err
);
   generate
      if (INT_MIN < 4 || FRAC_INT_MAX < INT_MIN) begin : g_bad_lim
         $error("fracn_ratio_gen: ratio limits inconsistent");
      end
      if (RST_INT < INT_MIN || RST_INT >= (1 << INT_W)) begin : g_bad_rint
         $error("fracn_ratio_gen: reset integer ratio out of range");
      end
      if (RST_REF < 1 || RST_REF >= (1 << REF_W)) begin : g_bad_rref
         $error("fracn_ratio_gen: reset reference ratio out of range");
      end
      if (FRAC_W < 2 || LP_ALIGN_LOG >= INT_W) begin : g_bad_w
         $error("fracn_ratio_gen: width parameters invalid");
      end
   endgenerate

   logic              ref_ok, fb_ok, mod_bypass;
   logic [INT_W-1:0]  fb_cnt;
   logic [FRAC_W-1:0] mod_frac;
   ofs_t              mod_offset;

   frg_cfg_check #(
      .REF_W(REF_W), .INT_W(INT_W), .INT_MIN(INT_MIN),
      .FRAC_INT_MAX(FRAC_INT_MAX), .LP_ALIGN_LOG(LP_ALIGN_LOG)
   ) u_check (
      .ref_div(ref_div), .int_div(int_div), .frac_mode(frac_mode),
      .lp_req(lp_req), .ref_ok(ref_ok), .fb_ok(fb_ok)
   );

   frg_ref_divider #(.REF_W(REF_W), .RST_REF(RST_REF)) u_refdiv (
      .clk(ref_clk), .rst_n(rst_n), .ref_div(ref_div),
      .ref_ok(ref_ok), .pulse(ref_pulse)
   );

   frg_fb_counter #(.INT_W(INT_W), .FRAC_W(FRAC_W), .RST_INT(RST_INT)) u_fbdiv (
      .clk(vco_clk), .rst_n(rst_n), .int_div(int_div), .frac_word(frac_word),
      .frac_mode(frac_mode), .fb_ok(fb_ok), .offset(mod_offset),
      .pulse(fb_pulse), .cnt(fb_cnt), .sel_frac(mod_frac), .bypass(mod_bypass)
   );

   frg_mash3 #(.FRAC_W(FRAC_W)) u_mash (
      .clk(vco_clk), .rst_n(rst_n), .step(fb_pulse), .bypass(mod_bypass),
      .frac_in(mod_frac), .offset(mod_offset)
   );

   always_ff @(posedge vco_clk or negedge rst_n) begin
      if (!rst_n) cfg_err <= 1'b0;
      else        cfg_err <= !(fb_ok && ref_ok);
   end
endmodule

// File: rtl/frg_checker.sv
module frg_checker
   import frg_pkg::*;
#(
   parameter int REF_W        = 10,
   parameter int INT_W        = 15,
   parameter int INT_MIN      = 36,
   parameter int FRAC_INT_MAX = 251,
   parameter int LP_ALIGN_LOG = 5
) (
   input logic             vco_clk,
   input logic             rst_n,
   input logic [REF_W-1:0] ref_div,
   input logic [INT_W-1:0] int_div,
   input logic             frac_mode,
   input logic             lp_req,
   input logic             cfg_err,
   input logic             fb_pulse,
   input logic [INT_W-1:0] fb_cnt,
   input ofs_t             offset,
   input logic             bypass
);
   logic misal;
   assign misal = (LP_ALIGN_LOG > 0) ? ((int_div & INT_W'((1 << LP_ALIGN_LOG) - 1)) != '0) : 1'b0;

   assert_ref_zero_err_R3: assert property (@(posedge vco_clk) disable iff (!rst_n)
      (ref_div == '0) |=> cfg_err);

   assert_int_low_err_R5: assert property (@(posedge vco_clk) disable iff (!rst_n)
      (int_div < INT_W'(INT_MIN)) |=> cfg_err);

   assert_frac_limit_R6: assert property (@(posedge vco_clk) disable iff (!rst_n)
      (frac_mode && int_div > INT_W'(FRAC_INT_MAX)) |=> cfg_err);

   assert_lp_align_R7: assert property (@(posedge vco_clk) disable iff (!rst_n)
      (lp_req && (frac_mode || misal)) |=> cfg_err);

   assert_offset_range_R8: assert property (@(posedge vco_clk) disable iff (!rst_n)
      fb_pulse |-> (offset >= -4'sd3 && offset <= 4'sd4));

   assert_bypass_zero_R9: assert property (@(posedge vco_clk) disable iff (!rst_n)
      (fb_pulse && bypass) |-> (offset == 4'sd0));

   assert_cnt_step_R10: assert property (@(posedge vco_clk) disable iff (!rst_n)
      !fb_pulse |=> (fb_cnt == $past(fb_cnt) - 1'b1));
endmodule

bind fracn_ratio_gen frg_checker #(
   .REF_W(REF_W), .INT_W(INT_W), .INT_MIN(INT_MIN),
   .FRAC_INT_MAX(FRAC_INT_MAX), .LP_ALIGN_LOG(LP_ALIGN_LOG)
) u_frg_checker (
   .vco_clk(vco_clk), .rst_n(rst_n), .ref_div(ref_div), .int_div(int_div),
   .frac_mode(frac_mode), .lp_req(lp_req), .cfg_err(cfg_err),
   .fb_pulse(fb_pulse), .fb_cnt(fb_cnt), .offset(mod_offset), .bypass(mod_bypass)
);

// File: tb/fracn_ratio_gen_bench.sv
module fracn_ratio_gen_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [9:0]  ref_div = 10'd1;
   logic [14:0] int_div = 15'd78;
   logic [19:0] frac_word = '0;
   logic        frac_mode = 1'b0;
   logic        lp_req = 1'b0;
   logic        ref_pulse, fb_pulse, cfg_err;

   int total = 0;
   int bad = 0;
   int exp_q[$];
   string tag_q[$];

   // reference model state
   int m_int = 78;
   int m_frac = 0;
   bit m_mode = 1'b0;
   int a1 = 0, a2 = 0, a3 = 0;
   int d2 = 0, d3 = 0, d33 = 0;

   always #5 clk = ~clk;

   fracn_ratio_gen u_fracn_ratio_gen (
      .ref_clk(clk), .vco_clk(clk), .rst_n(rst_n), .ref_div(ref_div),
      .int_div(int_div), .frac_word(frac_word), .frac_mode(frac_mode),
      .lp_req(lp_req), .ref_pulse(ref_pulse), .fb_pulse(fb_pulse), .cfg_err(cfg_err)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic bit cfg_legal(input int i, input bit mode, input bit lp);
      return (i >= 36) && !(mode && i > 251) && !(lp && (mode || (i % 32) != 0));
   endfunction

   function automatic int model_step();
      int y, s1, s2, s3, c1, c2, c3;
      if (cfg_legal(int'(int_div), frac_mode, lp_req)) begin
         m_int = int'(int_div); m_frac = int'(frac_word); m_mode = frac_mode;
      end
      if (!m_mode || m_frac == 0) begin
         a1 = 0; a2 = 0; a3 = 0; d2 = 0; d3 = 0; d33 = 0;
         return m_int;
      end
      s1 = a1 + m_frac; c1 = s1 >> 20; a1 = s1 & 32'hFFFFF;
      s2 = a2 + a1;     c2 = s2 >> 20; a2 = s2 & 32'hFFFFF;
      s3 = a3 + a2;     c3 = s3 >> 20; a3 = s3 & 32'hFFFFF;
      y = c1 + c2 - d2 + c3 - 2 * d3 + d33;
      d33 = d3; d3 = c3; d2 = c2;
      return m_int + y;
   endfunction

   // monitor: measures each feedback period and pops the scoreboard
   int ival = 0;
   bit started = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (fb_pulse) begin
            if (started && exp_q.size() > 0) begin
               int e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check(ival == e, t, ival, e);
            end
            started = 1'b1;
            ival = 1;
         end else begin
            ival++;
         end
      end
   end

   task automatic wait_fb();
      forever begin
         @(negedge clk);
         if (fb_pulse) break;
      end
   endtask

   task automatic wait_ref();
      forever begin
         @(negedge clk);
         if (ref_pulse) break;
      end
   endtask

   task automatic seg(input int i, input int f, input bit mode, input bit lp,
                      input int n, input bit exp_err, input string tag);
      for (int k = 0; k < n; k++) begin
         wait_fb();
         #1;
         if (k == 0) begin
            int_div = 15'(i); frac_word = 20'(f); frac_mode = mode; lp_req = lp;
         end
         exp_q.push_back(model_step());
         tag_q.push_back(tag);
         if (k == 1) check(cfg_err == exp_err, {tag, " flag"}, int'(cfg_err), int'(exp_err));
      end
   endtask

   task automatic seg_mid(input int i, input int f, input bit mode, input int n, input string tag);
      wait_fb();
      #1;
      exp_q.push_back(model_step());
      tag_q.push_back(tag);
      repeat (10) @(negedge clk);
      #1;
      int_div = 15'(i); frac_word = 20'(f); frac_mode = mode;
      for (int k = 0; k < n; k++) begin
         wait_fb();
         #1;
         exp_q.push_back(model_step());
         tag_q.push_back(tag);
      end
   endtask

   task automatic ref_case(input int d, input int exp_p, input bit exp_err, input string tag);
      int c;
      @(negedge clk);
      #1;
      ref_div = 10'(d);
      wait_ref();
      wait_ref();
      c = 0;
      forever begin
         @(negedge clk);
         c++;
         if (ref_pulse) break;
      end
      check(c == exp_p, tag, c, exp_p);
      check(cfg_err == exp_err, {tag, " flag"}, int'(cfg_err), int'(exp_err));
   endtask

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      #2_000_000;
      bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      check(cfg_err == 1'b0, "R1 err in reset", int'(cfg_err), 0);
      check(ref_pulse == 1'b1, "R1 ref pulse in reset", int'(ref_pulse), 1);
      rst_n = 1'b1;
      n = 0;
      forever begin
         @(negedge clk);
         n++;
         if (fb_pulse) break;
      end
      check(n == 77, "R1 first feedback pulse", n, 77);
      check(cfg_err == 1'b0, "R1 err after reset", int'(cfg_err), 0);

      seg(100, 12345, 1'b0, 1'b0, 4, 1'b0, "R4 integer 100");
      seg(300, 0, 1'b0, 1'b0, 3, 1'b0, "R5 integer 300");
      seg(20, 0, 1'b0, 1'b0, 3, 1'b1, "R5 below minimum");
      seg(64, 0, 1'b0, 1'b1, 3, 1'b0, "R7 aligned low power");
      seg(70, 0, 1'b0, 1'b1, 3, 1'b1, "R7 misaligned low power");
      seg(78, 808452, 1'b1, 1'b0, 40, 1'b0, "R8 ratio 78+808452");
      seg(300, 808452, 1'b1, 1'b0, 5, 1'b1, "R6 fractional over 251");
      seg_mid(61, 398459, 1'b1, 40, "R10 mid-period change");
      seg(61, 398459, 1'b1, 1'b0, 4, 1'b0, "R8 ratio 61+398459");
      seg(50, 0, 1'b1, 1'b0, 5, 1'b0, "R9 zero fraction");
      wait_fb();
      wait_fb();
      check(exp_q.size() == 0, "R8 scoreboard drained", exp_q.size(), 0);

      ref_case(5, 5, 1'b0, "R2 reference divide 5");
      ref_case(0, 5, 1'b1, "R3 zero reference keeps 5");
      ref_case(1, 1, 1'b0, "R2 reference divide 1");
      ref_case(3, 3, 1'b0, "R2 reference divide 3");
      finish_run();
   end
endmodule